// File: doc/BRIEF.md
# Triggered One-Shot Pulse Timer

This block holds sixteen one-shot pulse channels. Each has a down-counter and one output pin. Software loads a count and starts the channel, or the channel is started by a compare match against one of two free-running up-counters. The pin stays high while the countdown runs. When the count runs out, or a terminate match cuts it short, the pin drops and a sticky per-channel flag is set. An interrupt is raised from any flag whose enable bit is set.

Channels 0 to 7 form group one and use compare unit 1. Channels 8 to 15 form group two and use compare unit 2. Each channel has two compare values: a general compare and an output compare. With one compare used to start the channel and the other used to stop it, the block makes a pulse that begins at a programmed offset and can be truncated early.

Registers sit on a simple write strobe bus with a combinational read port. The address is split into a 2-bit region and a 4-bit index:

| Region | Index | Register |
|---|---|---|
| 0 | 0 | RUN |
| 0 | 1 | FLAG |
| 0 | 2 | IRQ enable |
| 0 | 3 | LINK |
| 0 | 4 | TERM enable |
| 0 | 5 | MODE |
| 0 | 6 | CEN (counter enable) |
| 0 | 7 | FRC1 |
| 0 | 8 | FRC2 |
| 1 | n | count of channel n |
| 2 | n | general compare of channel n |
| 3 | n | output compare of channel n |

The down-counters decrement only on cycles where the external `dn_tick` enable is high.

Top module: `oneshot_bank`

## Requirements
- R1: Writing 1 to bit n of RUN (address 0x00) starts channel n if its count is nonzero. `pulse_out[n]` is high from the next cycle. The count (address 0x10+n) drops by one on each cycle with `dn_tick` high and holds while `dn_tick` is low. RUN reads back the bits of the running channels. A write to a running channel's count is ignored.
- R2: When the count goes from 1 to 0, the pin drops on that edge, the channel's RUN bit clears and bit n of FLAG (address 0x01) is set. With `dn_tick` held high, a count of L gives a pulse exactly L cycles wide.
- R3: FLAG bits stay set until software writes 1 to them at address 0x01. Writing 0 leaves a flag unchanged.
- R4: `irq` is high exactly when some FLAG bit and the same bit of IRQ enable (address 0x02) are both set.
- R5: If bit n of LINK (address 0x03) is set, a start match for channel n starts it, and the pin rises one cycle after the match cycle. The free-running counter of unit u counts up by one each cycle from its written value (FRC1 at 0x07, FRC2 at 0x08) only while CEN (address 0x06) bit u-1 is set. Matches occur only while that bit is set. Unit 1 serves channels 0-7 and unit 2 serves channels 8-15.
- R6: For channels 0-7, MODE (address 0x05) bit n chooses the compare roles. With the bit at 0, a general compare match (0x20+n) starts the channel and an output compare match (0x30+n) terminates it. With the bit at 1, the roles are swapped. Channels 8-15 always start on the output compare and terminate on the general compare.
- R7: If bit n of TERM enable (address 0x04) is set, a terminate match while channel n runs drops the pin on the next edge and sets the flag. The unexpired count stays readable at 0x10+n.
- R8: If a terminate match and a start arrive in the same cycle, the terminate wins and the channel does not start. A start that arrives while the channel is already running has no effect on the pulse width.
- R9: Starting a channel whose count is 0 sets its flag at once and never raises its pin.
- R10: After reset all pins, flags, `irq` and registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dn_tick | input | 1 | Down-counter clock enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register address (region, index) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| pulse_out | output | 16 | One-shot pulse pins, one per channel |
| irq | output | 1 | Interrupt request |

## Verification
The table-driven pass starts channels in both groups with counts of 0, 1 and several larger values. It measures pulse widths, which separates an off-by-one in expiry from a zero-count fault. Linked runs each start from a known counter value, so the cycles at which the pin rises and falls show whether the start and terminate compare roles follow the mode bit and the group. Three further runs are kept separate because each would hide a different fault if merged: equal start and terminate compares, a restart and count write during a run, and a unit-gating run where the wrong unit is enabled. The stalled `dn_tick` run separates counting on the tick from counting on the system clock.

// File: rtl/oneshot_bank.sv
module oneshot_bank #(
  parameter int GRP = 8,
  parameter int CW  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dn_tick,
  input  logic                 bus_wr,
  input  logic [5:0]           bus_addr,
  input  logic [CW-1:0]        bus_wdata,
  output logic [CW-1:0]        bus_rdata,
  output logic [2*GRP-1:0]     pulse_out,
  output logic                 irq
);
  localparam int NCH = 2 * GRP;
  localparam int IW  = $clog2(NCH);
  localparam logic [IW-1:0] R_RUN = 0, R_FLG = 1, R_IEN = 2, R_LNK = 3,
                            R_TEN = 4, R_MOD = 5, R_CEN = 6, R_FR1 = 7, R_FR2 = 8;

  logic [NCH-1:0] run, flag, ien, link, ten;
  logic [GRP-1:0] mode;
  logic [1:0]     cen;
  logic [CW-1:0]  frc [2];
  logic [CW-1:0]  cnt [NCH];
  logic [CW-1:0]  gcmp [NCH];
  logic [CW-1:0]  ocmp [NCH];

  logic [1:0]    region;
  logic [IW-1:0] idx;
  logic          ctl_wr;
  logic [NCH-1:0] sw_set, flg_clr, start_req, term_hit, flg_set;

  assign region  = bus_addr[IW+1:IW];
  assign idx     = bus_addr[IW-1:0];
  assign ctl_wr  = bus_wr && region == 2'd0;
  assign sw_set  = (ctl_wr && idx == R_RUN) ? bus_wdata[NCH-1:0] : '0;
  assign flg_clr = (ctl_wr && idx == R_FLG) ? bus_wdata[NCH-1:0] : '0;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int U = (c >= GRP) ? 1 : 0;
    logic gm, om, st_m, tm_m;
    assign gm = cen[U] && frc[U] == gcmp[c];
    assign om = cen[U] && frc[U] == ocmp[c];
    if (c < GRP) begin : g_one
      assign st_m = mode[c] ? om : gm;
      assign tm_m = mode[c] ? gm : om;
    end else begin : g_two
      assign st_m = om;
      assign tm_m = gm;
    end
    assign start_req[c] = sw_set[c] | (link[c] & st_m);
    assign term_hit[c]  = ten[c] & tm_m;
    assign flg_set[c]   = run[c] ? (term_hit[c] | (dn_tick && cnt[c] == CW'(1)))
                                 : (!term_hit[c] && start_req[c] && cnt[c] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= '0; flag <= '0; ien <= '0; link <= '0; ten <= '0;
      mode <= '0; cen <= '0;
      frc[0] <= '0; frc[1] <= '0;
      for (int c = 0; c < NCH; c++) begin
        cnt[c] <= '0; gcmp[c] <= '0; ocmp[c] <= '0;
      end
    end else begin
      if (ctl_wr && idx == R_IEN) ien  <= bus_wdata[NCH-1:0];
      if (ctl_wr && idx == R_LNK) link <= bus_wdata[NCH-1:0];
      if (ctl_wr && idx == R_TEN) ten  <= bus_wdata[NCH-1:0];
      if (ctl_wr && idx == R_MOD) mode <= bus_wdata[GRP-1:0];
      if (ctl_wr && idx == R_CEN) cen  <= bus_wdata[1:0];
      if (ctl_wr && idx == R_FR1) frc[0] <= bus_wdata;
      else if (cen[0])            frc[0] <= frc[0] + 1'b1;
      if (ctl_wr && idx == R_FR2) frc[1] <= bus_wdata;
      else if (cen[1])            frc[1] <= frc[1] + 1'b1;
      flag <= (flag & ~flg_clr) | flg_set;
      for (int c = 0; c < NCH; c++) begin
        if (bus_wr && region == 2'd2 && idx == IW'(c)) gcmp[c] <= bus_wdata;
        if (bus_wr && region == 2'd3 && idx == IW'(c)) ocmp[c] <= bus_wdata;
        if (term_hit[c]) begin
          run[c] <= 1'b0;
        end else if (run[c]) begin
          if (dn_tick) begin
            cnt[c] <= cnt[c] - 1'b1;
            if (cnt[c] == CW'(1)) run[c] <= 1'b0;
          end
        end else begin
          if (start_req[c] && cnt[c] != '0) run[c] <= 1'b1;
          if (bus_wr && region == 2'd1 && idx == IW'(c)) cnt[c] <= bus_wdata;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (region)
      2'd0: begin
        if (idx == R_RUN) bus_rdata[NCH-1:0] = run;
        if (idx == R_FLG) bus_rdata[NCH-1:0] = flag;
        if (idx == R_IEN) bus_rdata[NCH-1:0] = ien;
        if (idx == R_LNK) bus_rdata[NCH-1:0] = link;
        if (idx == R_TEN) bus_rdata[NCH-1:0] = ten;
        if (idx == R_MOD) bus_rdata[GRP-1:0] = mode;
        if (idx == R_CEN) bus_rdata[1:0]     = cen;
        if (idx == R_FR1) bus_rdata          = frc[0];
        if (idx == R_FR2) bus_rdata          = frc[1];
      end
      2'd1:    bus_rdata = cnt[idx];
      2'd2:    bus_rdata = gcmp[idx];
      default: bus_rdata = ocmp[idx];
    endcase
  end

  assign pulse_out = run;
  assign irq       = |(flag & ien);
endmodule

// File: rtl/oneshot_bank_chk.sv
module oneshot_bank_chk #(
  parameter int NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic [5:0]     bus_addr,
  input logic [NCH-1:0] pulse_out,
  input logic [NCH-1:0] flag,
  input logic [NCH-1:0] start_req,
  input logic [NCH-1:0] term_hit,
  input logic           irq
);
  p_term_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (term_hit != '0) |=> ((pulse_out & $past(term_hit)) == '0));

  p_end_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pulse_out) & ~pulse_out & ~flag) == '0));

  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flag) & ~flag) != '0) |-> $past(bus_wr && bus_addr == 6'd1));

  p_irq_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag != '0));

  p_rise_needs_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~$past(pulse_out) & pulse_out & ~$past(start_req)) == '0));
endmodule

bind oneshot_bank oneshot_bank_chk #(.NCH(2*GRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .pulse_out(pulse_out), .flag(flag), .start_req(start_req),
  .term_hit(term_hit), .irq(irq)
);

// File: tb/oneshot_bank_test.sv
module oneshot_bank_test;
  logic clk = 0, rst_n = 0, dn_tick = 1, bus_wr = 0;
  logic [5:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [15:0] pulse_out;
  logic irq;
  int runs = 0, fails = 0;

  localparam int A_RUN = 0, A_FLG = 1, A_IEN = 2, A_LNK = 3, A_TEN = 4,
                 A_MOD = 5, A_CEN = 6, A_FR1 = 7, A_FR2 = 8,
                 A_CNT = 16, A_GEN = 32, A_OC = 48;
  localparam int NV = 6;
  localparam int T_CH [NV] = '{0, 5, 9, 15, 3, 12};
  localparam int T_LD [NV] = '{1, 4, 0, 13, 2, 7};

  oneshot_bank uut (.*);

  always #2.5 clk = ~clk;

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1; bus_addr = 6'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input int a, output int d);
    bus_addr = 6'(a);
    #0.5;
    d = int'(bus_rdata);
  endtask

  task automatic cleanup();
    wr(A_CEN, 0); wr(A_LNK, 0); wr(A_TEN, 0); wr(A_MOD, 0);
    wr(A_FLG, 16'hFFFF); wr(A_FR1, 0); wr(A_FR2, 0);
  endtask

  initial begin
    int v, w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 pins", int'(pulse_out), 0);
    chk("R10 irq", int'(irq), 0);
    rd(A_FLG, v); chk("R10 flags", v, 0);
    rd(A_CNT + 7, v); chk("R10 count", v, 0);

    for (int i = 0; i < NV; i++) begin
      wr(A_CNT + T_CH[i], T_LD[i]);
      wr(A_RUN, 1 << T_CH[i]);
      rd(A_RUN, v);
      chk("R1 run readback", (v >> T_CH[i]) & 1, T_LD[i] != 0);
      w = 0;
      while (pulse_out[T_CH[i]] && w < 100) begin w++; @(negedge clk); end
      chk(T_LD[i] == 0 ? "R9 zero width" : "R2 width", w, T_LD[i]);
      rd(A_FLG, v); chk("R2 flag", (v >> T_CH[i]) & 1, 1);
      rd(A_RUN, v); chk("R2 run cleared", (v >> T_CH[i]) & 1, 0);
      wr(A_FLG, 16'hFFFF);
    end

    wr(A_CNT + 4, 5);
    dn_tick = 0;
    wr(A_RUN, 16'h0010);
    repeat (10) @(negedge clk);
    chk("R1 hold pin", int'(pulse_out[4]), 1);
    rd(A_CNT + 4, v); chk("R1 hold count", v, 5);
    dn_tick = 1;
    w = 0;
    while (pulse_out[4] && w < 100) begin w++; @(negedge clk); end
    chk("R1 ticked width", w, 5);

    wr(A_FLG, 16'h0000);
    rd(A_FLG, v); chk("R3 sticky", (v >> 4) & 1, 1);
    chk("R4 irq off", int'(irq), 0);
    wr(A_IEN, 16'h0010);
    chk("R4 irq on", int'(irq), 1);
    wr(A_FLG, 16'h0010);
    rd(A_FLG, v); chk("R3 cleared", v, 0);
    chk("R4 irq cleared", int'(irq), 0);
    wr(A_IEN, 0);

    cleanup();
    wr(A_GEN + 0, 5); wr(A_OC + 0, 12); wr(A_CNT + 0, 100);
    wr(A_LNK, 1); wr(A_TEN, 1);
    wr(A_CEN, 1);
    for (int i = 1; i <= 13; i++) begin
      @(negedge clk);
      if (i == 5)  chk("R5 before match", int'(pulse_out[0]), 0);
      if (i == 6)  chk("R5 linked start", int'(pulse_out[0]), 1);
      if (i == 12) chk("R7 still high", int'(pulse_out[0]), 1);
      if (i == 13) chk("R7 terminated", int'(pulse_out[0]), 0);
    end
    rd(A_FLG, v); chk("R7 flag", v & 1, 1);
    rd(A_CNT + 0, v); chk("R7 residual", v, 94);

    cleanup();
    wr(A_GEN + 1, 12); wr(A_OC + 1, 5); wr(A_CNT + 1, 3);
    wr(A_MOD, 2); wr(A_LNK, 2); wr(A_TEN, 2);
    wr(A_CEN, 1);
    for (int i = 1; i <= 9; i++) begin
      @(negedge clk);
      if (i == 5) chk("R6 swap before", int'(pulse_out[1]), 0);
      if (i == 6) chk("R6 swap start on output compare", int'(pulse_out[1]), 1);
      if (i == 9) chk("R6 swap expired", int'(pulse_out[1]), 0);
    end
    rd(A_FLG, v); chk("R6 flag", (v >> 1) & 1, 1);

    cleanup();
    wr(A_OC + 8, 5); wr(A_CNT + 8, 2); wr(A_LNK, 16'h0100);
    wr(A_CEN, 1);
    v = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); v |= pulse_out[8]; end
    chk("R5 wrong unit no start", v, 0);
    wr(A_CEN, 0); wr(A_FR2, 0);
    wr(A_CEN, 2);
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (i == 5) chk("R6 group two before", int'(pulse_out[8]), 0);
      if (i == 6) chk("R6 group two start", int'(pulse_out[8]), 1);
    end

    cleanup();
    wr(A_GEN + 2, 7); wr(A_OC + 2, 7); wr(A_CNT + 2, 4);
    wr(A_LNK, 4); wr(A_TEN, 4);
    wr(A_CEN, 1);
    v = 0;
    for (int i = 0; i < 15; i++) begin @(negedge clk); v |= pulse_out[2]; end
    chk("R8 terminate wins pin", v, 0);
    rd(A_FLG, v); chk("R8 terminate wins flag", (v >> 2) & 1, 0);

    cleanup();
    wr(A_CNT + 3, 10);
    wr(A_RUN, 8);
    w = 0;
    fork
      for (int i = 0; i < 30; i++) begin
        if (pulse_out[3]) w++;
        @(negedge clk);
      end
      begin
        repeat (3) @(negedge clk);
        wr(A_RUN, 8);
        wr(A_CNT + 3, 50);
      end
    join
    chk("R8 restart ignored width", w, 10);
    rd(A_CNT + 3, v); chk("R1 count write ignored while running", v, 0);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule